// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Controller

This block is a serial peripheral port for a small processor-style register bus. Software picks the role, the bit order, the clock polarity and phase, and a clock divider through one control register. It then writes a byte into the data register. As master, the block makes the serial clock itself, shifts the byte out on MOSI and shifts in MISO at the same time. After sixteen clock edges it stops the clock by itself and raises a completion flag. As slave, the block takes the serial clock from outside and shifts its preloaded byte out on MISO while taking MOSI in. It does this only while the slave-select input is held low.

Reading the data register returns the byte received in the last completed transfer. The completion flag drives an interrupt request only when both the block's own interrupt enable and a separate serial-port enable input are set. The external slave-select and serial clock pass through two-stage synchronizers. A slave therefore follows a serial clock that is well below the system clock.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0 and the data register reads 0. irq, sclk_oe, mosi_oe and miso_oe are all low.
- R2: The control register sits at address 0 and reads back what was written. Its bits from 7 down to 0 are: interrupt enable, port enable, LSB-first, master, clock polarity, clock phase, divider bit 1, divider bit 0.
- R3: In master mode with the port enabled, a write to address 1 starts a transfer. After exactly 16 serial-clock edges the clock stops and status bit 7 (address 2) becomes 1.
- R4: irq is high exactly when status bit 7, control bit 7 and serial_int_en are all 1.
- R5: The LSB-first bit set to 0 sends and receives bit 7 first. Set to 1, it sends and receives bit 0 first.
- R6: When no master transfer is running, sclk_o equals the clock polarity bit (1 idles high, 0 idles low).
- R7: In slave mode, the block reacts to sclk_i and mosi_i only while ss_n_i is low. While ss_n_i is high, a clocked byte sets no flag, leaves the data register unchanged, and keeps miso_oe low.
- R8: Clock phase 0 puts the first bit out before the first edge, samples on leading edges and changes data on trailing edges. Clock phase 1 changes data on leading edges and samples on trailing edges.
- R9: The master serial-clock half period is 2, 8, 32 or 64 system clocks for divider codes 0, 1, 2 and 3 (divide by 4, 16, 64, 128).
- R10: Writing address 2 with bit 7 = 0 clears the completion flag. Writing bit 7 = 1 leaves the flag unchanged.
- R11: A data write made while a transfer is running is ignored. The byte in flight is not altered.
- R12: Reading address 1 returns the byte received in the most recent completed transfer.
- R13: In slave mode, a data write preloads the byte sent on miso_o during the next selected transfer, and the byte clocked in on mosi_i becomes readable at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| serial_int_en | input | 1 | Serial-port interrupt enable from outside |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Serial clock drive enable |
| sclk_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | MOSI drive enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | MISO drive enable |
| miso_i | input | 1 | Master data in |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The bench runs master transfers in all four polarity and phase combinations, both bit orders and every divider code, with asymmetric byte values. If the design swapped the bit order or the edge pairing, a scrambled byte would appear at the far end. If it mis-decoded a divider code, the measured half period would be wrong. One master transfer takes a second data write in mid-flight. A design that honoured that write would corrupt the outgoing stream. Slave runs clock a full byte with slave select high. A design that failed to gate on select would set the flag, overwrite the received byte or drive MISO. The interrupt sequence flips each of its three enables in turn and writes a 1 to the flag. This exposes any missing enable term and any flag that clears on the wrong value.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  localparam int WORD_W = 8;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] presc;
  } spi_ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam int         FLAG_BIT  = 7;
endpackage

// File: rtl/spi_port_regs.sv
`timescale 1ns/1ps
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              serial_int_en,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  output spi_ctrl_t         ctrl,
  output logic              flag,
  output logic              data_wr,
  output logic              irq
);
  spi_ctrl_t ctrl_q, ctrl_d;
  logic      flag_q, flag_d;
  logic      ctrl_we, stat_we;

  assign ctrl_we = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_we = reg_wr && (reg_addr == ADDR_STAT);
  assign data_wr = reg_wr && (reg_addr == ADDR_DATA);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = spi_ctrl_t'(reg_wdata);
    flag_d = flag_q;
    if (stat_we && !reg_wdata[FLAG_BIT]) flag_d = 1'b0;
    if (done) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_DATA: reg_rdata = rx_word;
      ADDR_STAT: reg_rdata = {flag_q, {(WORD_W-1){1'b0}}};
      default:   reg_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign flag = flag_q;
  assign irq  = flag_q & ctrl_q.irq_en & serial_int_en;
endmodule

// File: rtl/spi_port_clkgen.sv
`timescale 1ns/1ps
module spi_port_clkgen #(
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64,
  parameter int DIV3 = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       cpol,
  input  logic [1:0] presc,
  output logic       sclk,
  output logic       tick,
  output logic       lead
);
  localparam int HALF_MAX = DIV3 / 2;
  localparam int CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             sclk_q, sclk_d;

  always_comb begin
    case (presc)
      2'd0:    lim = CNT_W'(DIV0 / 2 - 1);
      2'd1:    lim = CNT_W'(DIV1 / 2 - 1);
      2'd2:    lim = CNT_W'(DIV2 / 2 - 1);
      default: lim = CNT_W'(DIV3 / 2 - 1);
    endcase
  end

  assign tick = run && (cnt_q == lim);
  assign lead = (sclk_q == cpol);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = cpol;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/spi_port_slvsync.sv
`timescale 1ns/1ps
module spi_port_slvsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic ss_n_i,
  input  logic cpol,
  output logic ev,
  output logic lead,
  output logic ss_act
);
  logic [STAGES-1:0] sclk_pipe, ss_pipe;
  logic              sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= '0;
      ss_pipe   <= '1;
      sclk_prev <= 1'b0;
    end else begin
      sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_i};
      ss_pipe   <= {ss_pipe[STAGES-2:0], ss_n_i};
      sclk_prev <= sclk_pipe[STAGES-1];
    end
  end

  assign ss_act = !ss_pipe[STAGES-1];
  assign ev     = ss_act && (sclk_pipe[STAGES-1] != sclk_prev);
  assign lead   = (sclk_prev == cpol);
endmodule

// File: rtl/spi_port_shift.sv
`timescale 1ns/1ps
module spi_port_shift
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              master,
  input  logic              lsb_first,
  input  logic              cpha,
  input  logic              slave_sel,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              ev,
  input  logic              ev_lead,
  input  logic              in_bit,
  output logic              out_bit,
  output logic              active,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d, hold_q, hold_d, rx_in, tx_adv;
  logic [EDGE_W-1:0] cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              sample, shift, last, abort, can_load;

  assign sample   = ev && (ev_lead ^ cpha);
  assign shift    = ev && !(ev_lead ^ cpha) && !(cpha && (cnt_q == '0));
  assign last     = ev && (cnt_q == EDGE_W'(EDGES - 1));
  assign abort    = !enable || (!master && !slave_sel);
  assign can_load = load && enable && !act_q;

  assign rx_in  = lsb_first ? {in_bit, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], in_bit};
  assign tx_adv = lsb_first ? {1'b0, tx_q[WORD_W-1:1]}   : {tx_q[WORD_W-2:0], 1'b0};

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    hold_d = hold_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    done   = 1'b0;
    if (abort) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (ev) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
      act_d = !last;
      if (sample) rx_d = rx_in;
      if (shift)  tx_d = tx_adv;
      if (last) begin
        hold_d = sample ? rx_in : rx_q;
        done   = 1'b1;
      end
    end
    if (can_load && !ev) begin
      tx_d  = load_word;
      cnt_d = '0;
      if (master) act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign out_bit = lsb_first ? tx_q[0] : tx_q[WORD_W-1];
  assign active  = act_q;
  assign rx_word = hold_q;
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV0        = 4,
  parameter int DIV1        = 16,
  parameter int DIV2        = 64,
  parameter int DIV3        = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       serial_int_en,
  output logic       irq,
  output logic       sclk_o,
  output logic       sclk_oe,
  input  logic       sclk_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i,
  input  logic       ss_n_i
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  spi_ctrl_t         ctrl;
  logic              flag, data_wr, done, active, run;
  logic              m_tick, m_lead, s_ev, s_lead, s_ss_act;
  logic              ev, ev_lead, in_bit, out_bit;
  logic [WORD_W-1:0] rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spi_port_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serial_int_en(serial_int_en),
    .done(done), .rx_word(rx_word), .ctrl(ctrl), .flag(flag),
    .data_wr(data_wr), .irq(irq)
  );

  assign run = active && ctrl.master && ctrl.enable;

  spi_port_clkgen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_clkgen (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .cpol(ctrl.cpol),
    .presc(ctrl.presc), .sclk(sclk_o), .tick(m_tick), .lead(m_lead)
  );

  spi_port_slvsync #(.STAGES(SYNC_STAGES)) u_slvsync (
    .clk(clk), .rst_n(rst_sync_n), .sclk_i(sclk_i), .ss_n_i(ss_n_i),
    .cpol(ctrl.cpol), .ev(s_ev), .lead(s_lead), .ss_act(s_ss_act)
  );

  assign ev      = ctrl.master ? m_tick : s_ev;
  assign ev_lead = ctrl.master ? m_lead : s_lead;
  assign in_bit  = ctrl.master ? miso_i : mosi_i;

  spi_port_shift u_shift (
    .clk(clk), .rst_n(rst_sync_n), .enable(ctrl.enable), .master(ctrl.master),
    .lsb_first(ctrl.lsb_first), .cpha(ctrl.cpha), .slave_sel(s_ss_act),
    .load(data_wr), .load_word(reg_wdata), .ev(ev), .ev_lead(ev_lead),
    .in_bit(in_bit), .out_bit(out_bit), .active(active), .done(done),
    .rx_word(rx_word)
  );

  assign sclk_oe = ctrl.enable && ctrl.master;
  assign mosi_oe = ctrl.enable && ctrl.master;
  assign mosi_o  = out_bit;
  assign miso_o  = out_bit;
  assign miso_oe = ctrl.enable && !ctrl.master && s_ss_act;
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk
  import spi_port_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input spi_ctrl_t ctrl,
  input logic      run,
  input logic      sclk_o,
  input logic      done,
  input logic      flag,
  input logic      irq,
  input logic      ss_act,
  input logic      active
);
  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk_o == $past(ctrl.cpol)));

  p_done_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  p_stop_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);

  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);

  p_slave_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.enable && !ctrl.master && !ss_act) |=> !active);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ctrl(ctrl), .run(run), .sclk_o(sclk_o),
  .done(done), .flag(flag), .irq(irq), .ss_act(s_ss_act), .active(active)
);

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       serial_int_en;
  logic       irq, sclk_o, sclk_oe, sclk_i, mosi_o, mosi_oe, mosi_i;
  logic       miso_o, miso_oe, miso_i, ss_n_i;

  int total = 0;
  int bad   = 0;
  int sclk_toggles = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      exp_tag[$];
  logic [7:0] obs_q[$];

  localparam int H = 12;

  always #2 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serial_int_en(serial_int_en),
    .irq(irq), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  always @(sclk_o) sclk_toggles++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // scoreboard monitor: compares each observed serial byte with the oldest expected one
  always @(negedge clk) begin
    if (obs_q.size() > 0) begin
      logic [7:0] o, e;
      string t;
      o = obs_q.pop_front();
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(t, {24'd0, o}, {24'd0, e});
      end else begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int idx(input bit lsb, input int k);
    return lsb ? k : 7 - k;
  endfunction

  task automatic master_xfer(input logic [7:0] cfg, input logic [7:0] tx,
                             input logic [7:0] slv, input int exp_half,
                             input bit poke, input bit keep);
    bit cpha, lsb, cpol;
    logic [7:0] cap, rd;
    time t0, t1;
    int tog0;
    cpha = cfg[2]; lsb = cfg[5]; cpol = cfg[3];
    cap = 8'h00; t0 = 0; t1 = 0;
    bus_write(2'd0, cfg);
    repeat (4) @(negedge clk);
    check("R6 idle level", {31'd0, sclk_o}, {31'd0, cpol});
    if (!cpha) miso_i = slv[idx(lsb, 0)];
    exp_q.push_back(tx);
    exp_tag.push_back(lsb ? "R5 R8 mosi byte lsb-first" : "R5 R8 mosi byte msb-first");
    tog0 = sclk_toggles;
    fork
      begin
        bus_write(2'd1, tx);
        if (poke) begin
          repeat (6) @(negedge clk);
          bus_write(2'd1, ~tx);  // R11: must be ignored
        end
      end
      begin
        for (int e = 0; e < 16; e++) begin
          @(sclk_o);
          if (e == 0) t0 = $time;
          if (e == 1) t1 = $time;
          #1;
          if (e % 2 == 0) begin
            if (!cpha) cap[idx(lsb, e / 2)] = mosi_o;
            else       miso_i = slv[idx(lsb, e / 2)];
          end else begin
            if (!cpha) begin
              if (e / 2 < 7) miso_i = slv[idx(lsb, e / 2 + 1)];
            end else begin
              cap[idx(lsb, e / 2)] = mosi_o;
            end
          end
        end
        check("R9 half period", int'((t1 - t0) / 4), exp_half);
        obs_q.push_back(cap);
      end
    join
    repeat (2 * exp_half + 4) @(negedge clk);
    check("R3 exactly 16 edges", sclk_toggles - tog0, 16);
    check("R6 idle after byte", {31'd0, sclk_o}, {31'd0, cpol});
    bus_read(2'd2, rd);
    check("R3 flag set", {24'd0, rd}, 32'h80);
    bus_read(2'd1, rd);
    check("R12 R5 received byte", {24'd0, rd}, {24'd0, slv});
    if (!keep) begin
      bus_write(2'd2, 8'h00);
      bus_read(2'd2, rd);
      check("R10 flag cleared", {24'd0, rd}, 32'h0);
    end
  endtask

  task automatic slave_xfer(input logic [7:0] cfg, input logic [7:0] dut_tx,
                            input logic [7:0] mst_tx, input bit sel);
    bit cpha, lsb;
    logic [7:0] cap, rd, prev_rx;
    cpha = cfg[2]; lsb = cfg[5];
    cap = 8'h00;
    ss_n_i = 1'b1;
    sclk_i = cfg[3];
    bus_write(2'd0, cfg);
    bus_write(2'd1, dut_tx);
    repeat (4) @(negedge clk);
    bus_read(2'd1, prev_rx);
    if (sel) begin
      ss_n_i = 1'b0;
      exp_q.push_back(dut_tx);
      exp_tag.push_back("R13 R8 R5 miso byte");
    end
    repeat (6) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      if (!cpha) begin
        mosi_i = mst_tx[idx(lsb, k)];
        repeat (H) @(negedge clk);
        cap[idx(lsb, k)] = miso_o;
        if (k == 3) check("R7 miso drive follows select", {31'd0, miso_oe}, {31'd0, sel});
        sclk_i = ~sclk_i;
        repeat (H) @(negedge clk);
        sclk_i = ~sclk_i;
      end else begin
        sclk_i = ~sclk_i;
        mosi_i = mst_tx[idx(lsb, k)];
        repeat (H) @(negedge clk);
        cap[idx(lsb, k)] = miso_o;
        if (k == 3) check("R7 miso drive follows select", {31'd0, miso_oe}, {31'd0, sel});
        sclk_i = ~sclk_i;
        repeat (H) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    if (sel) begin
      obs_q.push_back(cap);
      bus_read(2'd2, rd);
      check("R13 slave flag set", {24'd0, rd}, 32'h80);
      bus_read(2'd1, rd);
      check("R13 R12 slave received byte", {24'd0, rd}, {24'd0, mst_tx});
      bus_write(2'd2, 8'h00);
    end else begin
      bus_read(2'd2, rd);
      check("R7 no flag while deselected", {24'd0, rd}, 32'h0);
      bus_read(2'd1, rd);
      check("R7 data unchanged while deselected", {24'd0, rd}, {24'd0, prev_rx});
    end
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0;
    reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    serial_int_en = 1'b0;
    sclk_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0; ss_n_i = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); check("R1 ctrl reset", {24'd0, rd}, 32'h0);
    bus_read(2'd2, rd); check("R1 status reset", {24'd0, rd}, 32'h0);
    bus_read(2'd1, rd); check("R1 data reset", {24'd0, rd}, 32'h0);
    check("R1 outputs quiet", {28'd0, irq, sclk_oe, mosi_oe, miso_oe}, 32'h0);

    // R2 control readback
    bus_write(2'd0, 8'h2B);
    bus_read(2'd0, rd); check("R2 ctrl readback", {24'd0, rd}, 32'h2B);
    bus_write(2'd0, 8'h00);

    // master transfers: mode, order and divider sweep
    master_xfer(8'h50, 8'hA5, 8'h3C, 2,  1'b0, 1'b0);
    master_xfer(8'h55, 8'h96, 8'hC3, 8,  1'b1, 1'b0);   // R11 poke mid-transfer
    master_xfer(8'h7A, 8'h1E, 8'hB4, 32, 1'b0, 1'b0);
    master_xfer(8'h7F, 8'h6D, 8'h52, 64, 1'b0, 1'b0);

    // R4 / R10 interrupt gating
    serial_int_en = 1'b0;
    master_xfer(8'hD0, 8'h0F, 8'hF1, 2, 1'b0, 1'b1);
    @(negedge clk); check("R4 irq off without port enable", {31'd0, irq}, 32'd0);
    serial_int_en = 1'b1;
    @(negedge clk); check("R4 irq with all enables", {31'd0, irq}, 32'd1);
    bus_write(2'd0, 8'h50);
    @(negedge clk); check("R4 irq off without local enable", {31'd0, irq}, 32'd0);
    bus_write(2'd0, 8'hD0);
    bus_write(2'd2, 8'h80);
    @(negedge clk); check("R10 writing one keeps flag", {31'd0, irq}, 32'd1);
    bus_write(2'd2, 8'h00);
    @(negedge clk); check("R10 R4 clear drops irq", {31'd0, irq}, 32'd0);
    serial_int_en = 1'b0;

    // slave transfers
    slave_xfer(8'h40, 8'hC6, 8'h2B, 1'b1);
    slave_xfer(8'h6C, 8'h39, 8'hE4, 1'b1);
    slave_xfer(8'h40, 8'h77, 8'h5E, 1'b0);   // R7 deselected
    slave_xfer(8'h44, 8'h5A, 8'h0F, 1'b1);

    repeat (4) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    report();
    $finish;
  end
endmodule